// File: doc/BRIEF.md
# Status Register and Bit-Manipulation Unit

This block is an 8-bit datapath slice for a small RISC core. It owns the processor status byte and carries out the single-cycle operations that act on one register operand and on the flags: rotate right through carry, arithmetic shift right, nibble swap, setting or clearing any one status bit, copying an operand bit into the transfer flag, and copying the transfer flag into one bit of a result. The register file, instruction decode, add/subtract and interrupt handling sit outside. The global interrupt bit is only stored and shown on the status output.

Each operation is presented with a start strobe, an operation code, an 8-bit operand and a 3-bit bit index. The status byte and the result register update on the clock edge that samples the strobe. A one-cycle write enable tells the register file to take the result.

Top module: `sreg_bitops_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the status byte, the result and the result-write enable to zero.
- R2: Operation code 1 (rotate right through carry) gives a result whose bit 7 is the old carry, whose bit n is operand bit n+1 for n = 0..6, and sets carry to operand bit 0.
- R3: Operation code 2 (arithmetic shift right) gives a result whose bit 7 equals operand bit 7, whose bit n is operand bit n+1 for n = 0..6, and sets carry to operand bit 0.
- R4: After either shift, N is result bit 7, V is N xor C, S is N xor V, and Z is 1 exactly when the result is zero; the status bits I, T and H are unchanged. The status byte layout, bit 7 to bit 0, is I, T, H, S, V, N, Z, C.
- R5: Operation code 3 (nibble swap) gives a result with operand bits 3..0 in bits 7..4 and operand bits 7..4 in bits 3..0, and leaves the status byte unchanged.
- R6: Operation codes 4 (flag set) and 5 (flag clear) write 1 or 0 to the status bit whose position equals the bit index (0 = C up to 7 = I), leave the other status bits and the result unchanged, and do not raise the write enable.
- R7: Operation code 6 (bit store) copies operand bit [index] into T (status bit 6), changes no other status bit, and does not raise the write enable.
- R8: Operation code 7 (bit load) gives a result equal to the operand with bit [index] replaced by T, and leaves the status byte unchanged.
- R9: With start low, or with operation code 0 or 8..15, the status byte and the result keep their values and the write enable stays low.
- R10: Every operation takes one cycle: outputs show its effect right after the edge that samples start, the write enable is high for that one cycle only for codes 1, 2, 3 and 7, and a following operation sees the flags the previous one produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Executes the presented operation on this edge |
| op | input | 4 | Operation code |
| operand | input | 8 | Source register value |
| bit_idx | input | 3 | Bit position for set, clear, store and load |
| result | output | 8 | Last written result |
| result_we | output | 1 | Result-write enable, one cycle per writing operation |
| status | output | 8 | Status byte: I, T, H, S, V, N, Z, C from bit 7 down |

## Verification
The bench builds the block with its default width of 8, the only width the fixed status layout supports, which puts every operand value and every one of the eight bit positions within reach of a short run. Directed sequences sweep all indices through set, clear, store and load, and chain rotates so that a carry produced by one operation feeds the next. A long random stream with a random start strobe and codes outside the defined set then exercises idle cycles and ignored codes against the model.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    // Operation codes presented on the op port.
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_RORC = 4'd1,
        OP_ASHR = 4'd2,
        OP_NSWP = 4'd3,
        OP_FSET = 4'd4,
        OP_FCLR = 4'd5,
        OP_TSTO = 4'd6,
        OP_TLOD = 4'd7
    } sbu_op_e;

    // Status byte geometry; the bit index selects positions directly.
    localparam int STAT_W = 8;
    localparam int ST_C   = 0;
    localparam int ST_Z   = 1;
    localparam int ST_N   = 2;
    localparam int ST_V   = 3;
    localparam int ST_S   = 4;
    localparam int ST_H   = 5;
    localparam int ST_T   = 6;
    localparam int ST_I   = 7;

endpackage

// File: rtl/sbu_shifter.sv
module sbu_shifter
    import sbu_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2
) (
    input  sbu_op_e            op,
    input  logic [DATA_W-1:0]  operand,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               carry_in,
    input  logic               tflag_in,
    output logic [DATA_W-1:0]  res,
    output logic               res_wr,
    output logic               carry_out
);

    logic [DATA_W-1:0] load_val;

    // Bit load: one mux per result bit, picking the transfer flag at the index.
    for (genvar g = 0; g < DATA_W; g++) begin : g_tload
        always_comb begin
            load_val[g] = (bit_idx == IDX_W'(g)) ? tflag_in : operand[g];
        end
    end

    always_comb begin
        res       = operand;
        res_wr    = 1'b0;
        carry_out = operand[0];
        unique case (op)
            OP_RORC: begin
                res    = {carry_in, operand[DATA_W-1:1]};
                res_wr = 1'b1;
            end
            OP_ASHR: begin
                res    = {operand[DATA_W-1], operand[DATA_W-1:1]};
                res_wr = 1'b1;
            end
            OP_NSWP: begin
                res    = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
                res_wr = 1'b1;
            end
            OP_TLOD: begin
                res    = load_val;
                res_wr = 1'b1;
            end
            default: begin
                res    = operand;
                res_wr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sbu_flag_logic.sv
module sbu_flag_logic
    import sbu_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  sbu_op_e            op,
    input  logic [STAT_W-1:0]  stat_cur,
    input  logic [DATA_W-1:0]  operand,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0]  shift_res,
    input  logic               shift_carry,
    output logic [STAT_W-1:0]  stat_nxt
);

    logic neg_f;
    logic ovf_f;

    always_comb begin
        neg_f    = shift_res[DATA_W-1];
        ovf_f    = neg_f ^ shift_carry;
        stat_nxt = stat_cur;
        unique case (op)
            OP_RORC, OP_ASHR: begin
                stat_nxt[ST_C] = shift_carry;
                stat_nxt[ST_N] = neg_f;
                stat_nxt[ST_V] = ovf_f;
                stat_nxt[ST_S] = neg_f ^ ovf_f;
                stat_nxt[ST_Z] = (shift_res == '0);
            end
            OP_FSET: stat_nxt[bit_idx] = 1'b1;
            OP_FCLR: stat_nxt[bit_idx] = 1'b0;
            OP_TSTO: stat_nxt[ST_T]    = operand[bit_idx];
            default: stat_nxt = stat_cur;
        endcase
    end

endmodule

// File: rtl/sreg_bitops_unit.sv
module sreg_bitops_unit
    import sbu_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [3:0]         op,
    input  logic [DATA_W-1:0]  operand,
    input  logic [IDX_W-1:0]   bit_idx,
    output logic [DATA_W-1:0]  result,
    output logic               result_we,
    output logic [STAT_W-1:0]  status
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [DATA_W-1:0] res;
        logic              we;
    } unit_state_t;

    unit_state_t st_d, st_q;
    sbu_op_e     op_dec;
    logic [DATA_W-1:0] sh_res;
    logic              sh_wr;
    logic              sh_carry;
    logic [STAT_W-1:0] stat_nxt;

    assign op_dec = sbu_op_e'(op);

    sbu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op        (op_dec),
        .operand   (operand),
        .bit_idx   (bit_idx),
        .carry_in  (st_q.stat[ST_C]),
        .tflag_in  (st_q.stat[ST_T]),
        .res       (sh_res),
        .res_wr    (sh_wr),
        .carry_out (sh_carry)
    );

    sbu_flag_logic #(.DATA_W(DATA_W)) u_flags (
        .op          (op_dec),
        .stat_cur    (st_q.stat),
        .operand     (operand),
        .bit_idx     (bit_idx),
        .shift_res   (sh_res),
        .shift_carry (sh_carry),
        .stat_nxt    (stat_nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (start) begin
            st_d.stat = stat_nxt;
            if (sh_wr) begin
                st_d.res = sh_res;
                st_d.we  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result    = st_q.res;
    assign result_we = st_q.we;
    assign status    = st_q.stat;

    // R10: the write enable only follows a strobed operation.
    p_we_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        result_we |-> $past(start));

    // R9: no strobe, no status change.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(status));

    // R2: rotate moves old carry to the top and operand bit 0 into carry.
    p_rorc_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_RORC) |=>
            (status[ST_C] == $past(operand[0])) && (result[DATA_W-1] == $past(status[ST_C])));

    // R3: arithmetic shift keeps the sign bit.
    p_ashr_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_ASHR) |=> result[DATA_W-1] == $past(operand[DATA_W-1]));

    // R5: nibble swap leaves the flags alone.
    p_swap_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_NSWP) |=> $stable(status));

    // R6: flag set lands on the indexed status bit.
    p_fset_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_FSET) |=> status[$past(bit_idx)]);

    // R7: bit store lands in T.
    p_tsto_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_TSTO) |=> status[ST_T] == $past(operand[bit_idx]));

endmodule

// File: tb/sim_sreg_bitops_unit.sv
module sim_sreg_bitops_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] op;
    logic [7:0] operand;
    logic [2:0] bit_idx;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] status;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    int m_stat = 0;
    int m_res  = 0;
    int m_we   = 0;

    always #10 clk = ~clk;

    sreg_bitops_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
        .bit_idx(bit_idx), .result(result), .result_we(result_we), .status(status)
    );

    function automatic string tag_of(input int code, input int s);
        if (!s || code == 0 || code > 7) return "R9";
        case (code)
            1: return "R2/R4/R10";
            2: return "R3/R4";
            3: return "R5";
            4, 5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int bitv(input int v, input int p);
        return (v >> p) & 1;
    endfunction

    // Model of one clock edge given the applied inputs.
    task automatic model(input int code, input int a, input int idx, input int s);
        int r, c, n, v;
        m_we = 0;
        if (!s) return;
        case (code)
            1, 2: begin
                if (code == 1) r = (a >> 1) | (bitv(m_stat, 0) << 7);
                else           r = (a >> 1) | (a & 128);
                c = a & 1;
                n = bitv(r, 7);
                v = n ^ c;
                m_stat = m_stat & 8'hE0;
                m_stat = m_stat | c | ((r == 0) ? 2 : 0) | (n << 2) | (v << 3) | ((n ^ v) << 4);
                m_res = r; m_we = 1;
            end
            3: begin m_res = ((a << 4) | (a >> 4)) & 255; m_we = 1; end
            4: m_stat = m_stat | (1 << idx);
            5: m_stat = m_stat & ~(1 << idx) & 255;
            6: m_stat = (m_stat & 8'hBF) | (bitv(a, idx) << 6);
            7: begin
                m_res = (a & ~(1 << idx) & 255) | (bitv(m_stat, 6) << idx);
                m_we = 1;
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (status !== 8'(m_stat) || result !== 8'(m_res) || result_we !== 1'(m_we)) begin
            n_fail++;
            $display("FAIL %s: status=%h result=%h we=%b expected status=%h result=%h we=%0d",
                     tag, status, result, result_we, 8'(m_stat), 8'(m_res), m_we);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic apply(input int code, input int a, input int idx, input int s);
        start   = 1'(s);
        op      = 4'(code);
        operand = 8'(a);
        bit_idx = 3'(idx);
        model(code, a, idx, s);
        @(negedge clk);
        compare(tag_of(code, s));
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; operand = '0; bit_idx = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_stat = 0; m_res = 0; m_we = 0;
        compare("R1");                                     // reset state

        // R6 and R2/R4: set carry, rotate 0x01 -> 0x80, C=1 N=1 V=0 S=1
        apply(4, 0, 0, 1);
        apply(1, 8'h01, 0, 1);
        // R10: chained rotate consumes the carry just produced
        apply(1, 8'h00, 0, 1);
        apply(1, 8'h00, 0, 1);                             // R4: zero result sets Z
        // R3: sign kept
        apply(2, 8'h81, 0, 1);
        apply(2, 8'h7E, 0, 1);
        // R5
        apply(3, 8'hA5, 0, 1);
        // R6 over all positions, set then clear
        for (int i = 0; i < 8; i++) apply(4, 0, i, 1);
        for (int i = 0; i < 8; i++) apply(5, 8'hFF, i, 1);
        // R7 and R8 over all positions
        for (int i = 0; i < 8; i++) begin
            apply(6, 8'h5A, i, 1);
            apply(7, 8'h00, i, 1);
            apply(7, 8'hFF, (i + 3) % 8, 1);
        end
        // R9: idle strobe and unused codes
        apply(1, 8'hFF, 0, 0);
        for (int k = 8; k < 16; k++) apply(k, 8'h3C, k % 8, 1);
        apply(0, 8'h3C, 2, 1);

        // Random stream
        for (int k = 0; k < 3000; k++) begin
            int code;
            code = ($urandom_range(0, 9) == 0) ? $urandom_range(8, 15) : $urandom_range(0, 7);
            apply(code, $urandom_range(0, 255), $urandom_range(0, 7),
                  ($urandom_range(0, 5) != 0) ? 1 : 0);
        end

        // R1: reset mid-run clears everything
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_stat = 0; m_res = 0; m_we = 0;
        compare("R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule